// File: doc/BRIEF.md
# ATM Cell Segmentation Engine

This block sits on the transmit side of a cell interface. It takes a stream of 32-bit payload words from the host and cuts it into 12-word (48-byte) cell payloads. For each cell it presents a 32-bit cell header and that header's 8-bit check byte on a side channel. The header and check byte are valid together with the first payload word, so a downstream framer can build the full 53-byte cell. The host loads one prototype header, and every cell that follows uses it. Choosing the virtual channel is left to host software, and cells of different channels are never interleaved inside one data unit.

The host marks the last word of a data unit with an end flag. The engine then fills the rest of the cell with zero words. In AAL-5 mode it also places an 8-byte trailer in the last two words of the final cell, carrying the unit's byte length and a CRC-32 over the whole unit. It sets the end-of-unit bit in that cell's header. The engine works store-and-forward: it fills an internal cell buffer, then drains it. This means the header of a cell can depend on whether the cell is the last one, even though the header leaves with the cell's first word.

Top module: `seg_engine`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: A word on hdr_wdata with hdr_wr high becomes the prototype header. Every cell then shows it on out_hdr while out_sof is 1. Only bit 1, the end-of-unit bit, may be forced to 1 (see R8).
- R3: out_hec is computed over out_hdr, taking the bits MSB first from bit 31 down. It is a CRC-8 with polynomial x^8+x^2+x+1 (0x07) and initial value 0, and the result is XORed with 0x55.
- R4: Each cell is exactly 12 output beats. Payload words come out in the order they were accepted. out_sof is 1 on the first beat of each cell and 0 on the other 11.
- R5: The engine is store-and-forward: in_ready is 0 whenever out_valid is 1.
- R6: While out_valid is 1 and out_ready is 0, out_valid, out_data and out_sof hold their values.
- R7: With aal5_en at 0, an accepted word with in_last set ends the unit. The rest of its cell is zero words, and bit 1 of out_hdr equals the prototype's bit 1.
- R8: With aal5_en at 1, the final cell of a unit has this layout. Beat 10 is {8'h00 user byte, 8'h00 indication byte, 16-bit length}. Beat 11 is the CRC-32 value. out_hdr bit 1 is 1 on that cell only.
- R9: The CRC-32 is computed over every byte of beats 0 to 10 of all cells of the unit, MSB first within each word. It uses polynomial 0x04C11DB7 with an all-ones preset, and the complement of the result is sent.
- R10: With aal5_en at 1, if the last data word falls in beat 10 or 11, one extra cell is sent, made of 10 zero words and the trailer.
- R11: The length field is 4 times the number of data words of the unit, modulo 65536. Length and CRC start again from zero and the preset for the next unit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| hdr_wr | input | 1 | Load strobe for the prototype header |
| hdr_wdata | input | 32 | Prototype header value |
| aal5_en | input | 1 | 1 adds the AAL-5 trailer and the end bit |
| in_valid | input | 1 | Payload word valid |
| in_data | input | 32 | Payload word, first byte in bits 31:24 |
| in_last | input | 1 | Marks the last word of a data unit |
| in_ready | output | 1 | Engine accepts a payload word |
| out_valid | output | 1 | Cell beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | 32 | Cell payload word |
| out_sof | output | 1 | First beat of a cell |
| out_hdr | output | 32 | Cell header, meaningful while out_sof is 1 |
| out_hec | output | 8 | Header check byte for out_hdr |

## Verification
The assertions take for granted that aal5_en and the prototype header stay stable from the first word of a unit until its last cell has drained. They also assume that in_last is only meaningful together with in_valid. The bench changes mode and header only after the expected-beat queue is empty and in_ready is high again. It drives in_last only on a unit's final word. It applies back-pressure on out_ready in a fixed pattern and in one long stall, so the hold and exclusion properties are exercised while those input assumptions still hold.

// File: rtl/seg_pkg.sv
package seg_pkg;

  typedef enum logic [2:0] {
    ST_FILL  = 3'd0,
    ST_ZERO  = 3'd1,
    ST_LEN   = 3'd2,
    ST_CHK   = 3'd3,
    ST_DRAIN = 3'd4
  } seg_state_t;

  // Header check byte: CRC-8 (x^8+x^2+x+1), MSB first, offset 0x55.
  function automatic logic [7:0] hdr_check(input logic [31:0] h);
    logic [7:0] c;
    logic       fb;
    c = 8'h00;
    for (int i = 31; i >= 0; i--) begin
      fb = c[7] ^ h[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h07;
    end
    return c ^ 8'h55;
  endfunction

  // One 32-bit word folded into the running CRC-32, MSB first.
  function automatic logic [31:0] crc32_fold(input logic [31:0] c_in,
                                             input logic [31:0] w);
    logic [31:0] c;
    logic        fb;
    c = c_in;
    for (int i = 31; i >= 0; i--) begin
      fb = c[31] ^ w[i];
      c  = {c[30:0], 1'b0};
      if (fb) c = c ^ 32'h04C1_1DB7;
    end
    return c;
  endfunction

endpackage

// File: rtl/seg_hec.sv
module seg_hec (
  input  logic [31:0] hdr,
  output logic [7:0]  hec
);
  import seg_pkg::*;
  always_comb hec = hdr_check(hdr);
endmodule

// File: rtl/seg_crc32.sv
module seg_crc32 (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        upd,
  input  logic [31:0] word,
  output logic [31:0] crc_q
);
  import seg_pkg::*;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc_q <= '1;
    else if (upd)      crc_q <= crc32_fold(crc_q, word);
  end

  // R9: a new unit starts from the all-ones preset
  p_preset_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> crc_q == 32'hFFFF_FFFF);

endmodule

// File: rtl/seg_cellbuf.sv
module seg_cellbuf #(
  parameter int DEPTH = 12,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];

  // R4: every write lands inside one cell's slots
  p_wr_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < DEPTH);

endmodule

// File: rtl/seg_engine.sv
module seg_engine #(
  parameter int CELL_WORDS = 12,
  parameter int LEN_W      = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_wr,
  input  logic [31:0] hdr_wdata,
  input  logic        aal5_en,
  input  logic        in_valid,
  input  logic [31:0] in_data,
  input  logic        in_last,
  output logic        in_ready,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_sof,
  output logic [31:0] out_hdr,
  output logic [7:0]  out_hec
);
  import seg_pkg::*;

  localparam int AW = $clog2(CELL_WORDS);
  localparam logic [AW-1:0] LAST_IDX = AW'(CELL_WORDS - 1);
  localparam logic [AW-1:0] PRE_TRL  = AW'(CELL_WORDS - 3);
  localparam logic [LEN_W-1:0] WORD_BYTES = LEN_W'(4);

  seg_state_t        state;
  logic [AW-1:0]     wcnt, rcnt;
  logic              pend_end, cell_last;
  logic [LEN_W-1:0]  len_q;
  logic [31:0]       hdr_q;
  logic [31:0]       crc_q;

  // named events
  logic        acc_in, acc_out, cell_done, unit_done;
  logic        wr_en, crc_upd;
  logic [31:0] wr_data;
  logic        end_cell;

  assign in_ready  = (state == ST_FILL);
  assign out_valid = (state == ST_DRAIN);
  assign acc_in    = in_valid && in_ready;
  assign acc_out   = out_valid && out_ready;
  assign cell_done = acc_out && (rcnt == LAST_IDX);
  assign unit_done = cell_done && cell_last;
  assign end_cell  = aal5_en && cell_last;

  always_comb begin
    wr_en   = 1'b0;
    wr_data = '0;
    case (state)
      ST_FILL: begin wr_en = acc_in; wr_data = in_data; end
      ST_ZERO: begin wr_en = 1'b1;   wr_data = '0; end
      ST_LEN:  begin wr_en = 1'b1;   wr_data = {16'h0000, 16'(len_q)}; end
      ST_CHK:  begin wr_en = 1'b1;   wr_data = ~crc_q; end
      default: ;
    endcase
  end
  assign crc_upd = wr_en && (state != ST_CHK);

  seg_cellbuf #(.DEPTH(CELL_WORDS), .W(32)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wcnt),
    .wr_data(wr_data), .rd_addr(rcnt), .rd_data(out_data)
  );

  seg_crc32 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(unit_done), .upd(crc_upd),
    .word(wr_data), .crc_q(crc_q)
  );

  assign out_sof = out_valid && (rcnt == '0);
  assign out_hdr = {hdr_q[31:2], hdr_q[1] | end_cell, hdr_q[0]};

  seg_hec u_hec (.hdr(out_hdr), .hec(out_hec));

  always_ff @(posedge clk) begin
    if (!rst_n) hdr_q <= '0;
    else if (hdr_wr) hdr_q <= hdr_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || unit_done) len_q <= '0;
    else if (acc_in)         len_q <= len_q + WORD_BYTES;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_FILL;
      wcnt      <= '0;
      rcnt      <= '0;
      pend_end  <= 1'b0;
      cell_last <= 1'b0;
    end else begin
      case (state)
        ST_FILL: if (acc_in) begin
          wcnt <= wcnt + 1'b1;
          if (in_last) pend_end <= 1'b1;
          if (wcnt == LAST_IDX) begin
            wcnt      <= '0;
            state     <= ST_DRAIN;
            cell_last <= in_last && !aal5_en;
          end else if (in_last) begin
            state <= (aal5_en && wcnt == PRE_TRL) ? ST_LEN : ST_ZERO;
          end
        end
        ST_ZERO: begin
          wcnt <= wcnt + 1'b1;
          if (wcnt == LAST_IDX) begin
            wcnt      <= '0;
            state     <= ST_DRAIN;
            cell_last <= !aal5_en;
          end else if (aal5_en && wcnt == PRE_TRL) begin
            state <= ST_LEN;
          end
        end
        ST_LEN: begin
          wcnt  <= wcnt + 1'b1;
          state <= ST_CHK;
        end
        ST_CHK: begin
          wcnt      <= '0;
          state     <= ST_DRAIN;
          cell_last <= 1'b1;
        end
        default: if (acc_out) begin
          rcnt <= rcnt + 1'b1;
          if (rcnt == LAST_IDX) begin
            rcnt <= '0;
            if (cell_last) begin
              state     <= ST_FILL;
              cell_last <= 1'b0;
              pend_end  <= 1'b0;
            end else if (pend_end) begin
              state <= ST_ZERO;
            end else begin
              state <= ST_FILL;
            end
          end
        end
      endcase
    end
  end

  // R6: a stalled beat is held
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_sof));

  // R5: filling and draining never overlap
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));

  // R4: a cell start is followed by a non-start beat
  p_sof_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    acc_out && out_sof |=> !out_sof);

  // R8: the end bit is only added in AAL-5 mode
  p_endbit_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !aal5_en |-> out_hdr == hdr_q);

endmodule

// File: tb/seg_engine_bench.sv
module seg_engine_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hdr_wr = 1'b0;
  logic [31:0] hdr_wdata = '0;
  logic        aal5_en = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_ready;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [31:0] out_data;
  logic        out_sof;
  logic [31:0] out_hdr;
  logic [7:0]  out_hec;

  always #10 clk = ~clk;   // 50 MHz

  seg_engine u_seg_engine (
    .clk(clk), .rst_n(rst_n), .hdr_wr(hdr_wr), .hdr_wdata(hdr_wdata),
    .aal5_en(aal5_en), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .in_ready(in_ready), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_sof(out_sof),
    .out_hdr(out_hdr), .out_hec(out_hec)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  int sof_cnt = 0;
  bit stall_force = 1'b0;

  logic [31:0] q_data[$];
  bit          q_sof[$];
  logic [31:0] q_hdr[$];
  string       q_tag[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bench forms of the checks: byte-at-a-time
  function automatic logic [7:0] ref_hec(input logic [31:0] h);
    logic [7:0] c = 8'h00;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ h[b*8 +: 8];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  function automatic logic [31:0] ref_crc_word(input logic [31:0] c_in,
                                               input logic [31:0] w);
    logic [31:0] c = c_in;
    for (int b = 3; b >= 0; b--) begin
      c = c ^ {w[b*8 +: 8], 24'h0};
      for (int k = 0; k < 8; k++) c = c[31] ? ((c << 1) ^ 32'h04C1_1DB7) : (c << 1);
    end
    return c;
  endfunction

  function automatic logic [31:0] pat(input int p, input int k);
    return {8'(p) + 8'h5A, 8'(k * 37 + 3), 8'(k), 8'(p * 11 + 1)};
  endfunction

  // builds the expected beats of one unit
  task automatic expect_unit(input bit a5, input int n, input logic [31:0] hdr,
                             input int p);
    int cells, total;
    logic [31:0] w [36];
    string t [36];
    logic [31:0] crc;
    cells = a5 ? (n + 2 + 11) / 12 : (n + 11) / 12;
    total = cells * 12;
    for (int k = 0; k < total; k++) begin
      w[k] = (k < n) ? pat(p, k) : 32'h0;
      t[k] = (k < n) ? "R4 data" : "R7 pad";
    end
    if (a5) begin
      w[total-2] = {16'h0, 16'(n * 4)};
      t[total-2] = "R11 length";
      crc = 32'hFFFF_FFFF;
      for (int k = 0; k < total - 1; k++) crc = ref_crc_word(crc, w[k]);
      w[total-1] = ~crc;
      t[total-1] = "R9 crc";
    end
    for (int k = 0; k < total; k++) begin
      q_data.push_back(w[k]);
      q_sof.push_back(k % 12 == 0);
      q_hdr.push_back((a5 && k >= total - 12) ? (hdr | 32'h2) : hdr);
      q_tag.push_back(t[k]);
    end
  endtask

  task automatic check_beat();
    logic [31:0] ed, eh;
    bit es;
    string tg;
    if (q_data.size() == 0) begin
      chk(1'b0, "R4 unexpected beat", out_data, 32'h0);
      return;
    end
    ed = q_data.pop_front(); es = q_sof.pop_front();
    eh = q_hdr.pop_front();  tg = q_tag.pop_front();
    chk(out_data == ed, tg, out_data, ed);
    chk(out_sof == es, "R4 sof", 32'(out_sof), 32'(es));
    if (out_sof) sof_cnt++;
    if (es) begin
      chk(out_hdr == eh, eh[1] ? "R8 header" : "R2 header", out_hdr, eh);
      chk(out_hec == ref_hec(eh), "R3 hec", 32'(out_hec), 32'(ref_hec(eh)));
    end
  endtask

  // receiver: sets ready at the falling edge, checks the beat taken next rise
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      out_ready = !stall_force && (cyc % 5 != 2);
      #1;
      if (rst_n && out_valid && out_ready) check_beat();
    end
  end

  task automatic send_unit(input int n, input int p);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = pat(p, k);
      in_last  = (k == n - 1);
      #1;
      while (!in_ready) begin
        @(negedge clk);
        #1;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic wait_drained();
    while (q_data.size() != 0 || !in_ready) @(negedge clk);
  endtask

  task automatic setup_unit(input bit a5, input logic [31:0] hdr);
    @(negedge clk);
    aal5_en   = a5;
    hdr_wr    = 1'b1;
    hdr_wdata = hdr;
    @(negedge clk);
    hdr_wr = 1'b0;
  endtask

  // {aal5, data words, header, expected cells}
  localparam logic [44:0] VEC [10] = '{
    {1'b0, 8'd12, 32'h0012_3450, 4'd1},
    {1'b0, 8'd5,  32'h0ABC_DEF2, 4'd1},
    {1'b0, 8'd24, 32'h1000_0020, 4'd2},
    {1'b1, 8'd10, 32'h0000_0050, 4'd1},
    {1'b1, 8'd11, 32'h0345_6780, 4'd2},
    {1'b1, 8'd12, 32'hFFFF_FFF0, 4'd2},
    {1'b1, 8'd3,  32'h0001_0010, 4'd1},
    {1'b1, 8'd22, 32'h00A0_0B00, 4'd2},
    {1'b1, 8'd23, 32'h0BAD_0C00, 4'd3},
    {1'b1, 8'd1,  32'h0000_0000, 4'd1}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1 reset in_ready", 32'(in_ready), 32'h1);
    chk(out_valid == 1'b0, "R1 reset out_valid", 32'(out_valid), 32'h0);

    for (int v = 0; v < 10; v++) begin
      int base;
      wait_drained();
      setup_unit(VEC[v][44], VEC[v][35:4]);
      expect_unit(VEC[v][44], int'(VEC[v][43:36]), VEC[v][35:4], v);
      base = sof_cnt;
      send_unit(int'(VEC[v][43:36]), v);
      wait_drained();
      chk(sof_cnt - base == int'(VEC[v][3:0]), "R10 cell count",
          32'(sof_cnt - base), 32'(VEC[v][3:0]));
    end

    // directed: long stall on a full cell (R5, R6)
    begin
      logic [31:0] held;
      stall_force = 1'b1;
      setup_unit(1'b0, 32'h0777_7770);
      expect_unit(1'b0, 12, 32'h0777_7770, 40);
      send_unit(12, 40);
      while (!out_valid) @(negedge clk);
      #2;
      held = out_data;
      repeat (4) @(negedge clk);
      #2;
      chk(out_valid == 1'b1, "R6 valid held", 32'(out_valid), 32'h1);
      chk(out_data == held, "R6 data held", out_data, held);
      chk(in_ready == 1'b0, "R5 no fill while draining", 32'(in_ready), 32'h0);
      stall_force = 1'b0;
      wait_drained();
    end

    // directed: back-to-back AAL-5 units restart length and CRC (R11)
    wait_drained();
    setup_unit(1'b1, 32'h0123_4560);
    expect_unit(1'b1, 7, 32'h0123_4560, 50);
    send_unit(7, 50);
    expect_unit(1'b1, 7, 32'h0123_4560, 50);
    send_unit(7, 50);
    wait_drained();
    chk(q_data.size() == 0, "R11 second unit drained", 32'(q_data.size()), 32'h0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule